// File: doc/BRIEF.md
# Speculative Branch Mask Tracker

This block keeps account of the conditional branches that a speculative core has predicted but not yet resolved, and of which in-flight instructions depend on each of them. Up to four branches may be outstanding. Each accepted branch receives a one-hot tag, and each instruction issued into one of sixteen tracking slots records a dependency mask: the set of tags that were outstanding when it issued.

When a branch resolves as correctly predicted, its tag drops out of every recorded mask and returns to the free pool in one cycle. The instructions that depended on it stay live and may later write back. When a branch resolves as mispredicted, every tracked instruction whose mask holds that tag is marked killed, so its result is discarded rather than written back. The faulting tag is freed, and so is every tag allocated while it was outstanding, because those branches lie on the wrong path. Only the wrong-path instructions are squashed; older, independent work is kept.

The surrounding core allocates tags at decode, writes slots at issue, releases slots at retire or discard, and feeds branch outcomes back from execution.

Top module: `brmask_tracker`

## Requirements
- R1: After reset no tag is outstanding, `tags_full` is 0, and every slot reads valid 0, mask 0 and kill 0.
- R2: A request while a tag is free is granted in the same cycle. `alloc_tag` is one-hot with the lowest-numbered free tag set (bit n means tag n). That tag shows in `live_tags` from the next cycle.
- R3: While all four tags are outstanding, `tags_full` is 1 and a request is refused: `alloc_grant` is 0 and `alloc_tag` is 0.
- R4: An issue writes the addressed slot with valid 1 and kill 0. Its mask is the outstanding tags plus any tag granted in the same cycle, so a live, unkilled slot never holds a tag that is not outstanding.
- R5: A correctly predicted resolution of an outstanding tag clears that bit in every slot mask and in `live_tags` on the next cycle. The slots stay valid and unkilled.
- R6: A mispredicted resolution of an outstanding tag sets kill on the next cycle in every valid slot whose mask holds that tag. Other slots keep their kill state.
- R7: A misprediction frees the faulting tag and every outstanding tag allocated while it was outstanding. The bits of all freed tags are cleared from every slot mask.
- R8: No allocation is granted in a cycle in which a misprediction of an outstanding tag is reported.
- R9: A resolution naming a tag that is not outstanding changes neither `live_tags` nor any slot.
- R10: A release clears valid, mask and kill of the addressed slot on the next cycle. When a release and an issue name the same slot in one cycle, the issue wins.
- R11: A resolution in the cycle of an issue also applies to the newly written slot. A correct outcome leaves the bit out of its mask; a misprediction kills it when its mask holds the faulting tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request a tag for a newly decoded branch |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_tag | output | 4 | One-hot tag granted this cycle, 0 when none |
| tags_full | output | 1 | All tags outstanding |
| issue_valid | input | 1 | Write an issued instruction into a slot |
| issue_slot | input | 4 | Slot index for the issue |
| release_valid | input | 1 | Free a slot |
| release_slot | input | 4 | Slot index for the release |
| resolve_valid | input | 1 | A branch outcome is reported |
| resolve_tag | input | 4 | One-hot tag of the resolved branch |
| resolve_mispredict | input | 1 | 1 when the prediction was wrong |
| live_tags | output | 4 | Tags currently outstanding |
| slot_valid | output | 16 | Per-slot valid bits |
| slot_mask | output | 64 | Per-slot dependency masks, slot i in bits [4i+3:4i] |
| slot_kill | output | 16 | Per-slot killed flags |

## Verification
Directed sequences fill the pool to refusal. They then resolve a middle tag correctly, which tells clearing one bit from emptying a mask. A branch allocated after others is mispredicted, and that shows whether only dependent slots are killed and only younger tags are freed. Same-cycle pairings follow: issue with allocation, issue with either outcome, issue with release, and allocation with a misprediction. Each pairing separates the documented priority from its plausible alternative. A long pseudo-random stretch then mixes every input against a behavioural model and exercises tag reuse after squashes.

// File: rtl/brmask_pkg.sv
package brmask_pkg;
  localparam int TAGS = 4;

  typedef logic [TAGS-1:0] tagv_t;
  typedef tagv_t [TAGS-1:0] dep_arr_t;

  // One-hot of the lowest clear bit of busy, zero when every bit is set.
  function automatic tagv_t lowest_free(tagv_t busy);
    tagv_t r;
    r = '0;
    for (int i = TAGS - 1; i >= 0; i--) begin
      if (!busy[i]) r = tagv_t'(1) << i;
    end
    return r;
  endfunction

  // Faulting tag plus every live tag whose ancestry holds it.
  function automatic tagv_t squash_set(tagv_t live, dep_arr_t dep, tagv_t bad);
    tagv_t r;
    r = bad;
    for (int t = 0; t < TAGS; t++) begin
      if (live[t] && ((dep[t] & bad) != '0)) r[t] = 1'b1;
    end
    return r;
  endfunction

  // Dependency mask written for an instruction issued this cycle.
  function automatic tagv_t issue_mask(tagv_t live, tagv_t granted, tagv_t cleared);
    return (live | granted) & ~cleared;
  endfunction
endpackage

// File: rtl/brmask_tag_pool.sv
module brmask_tag_pool
  import brmask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc_req,
  input  tagv_t ok_set,
  input  tagv_t bad_set,
  output tagv_t live,
  output tagv_t grant_tag,
  output tagv_t free_set,
  output logic  grant,
  output logic  full
);
  tagv_t    live_q;
  dep_arr_t dep_q;

  assign live      = live_q;
  assign full      = &live_q;
  assign grant     = alloc_req & ~full & ~(|bad_set);
  assign grant_tag = grant ? lowest_free(live_q) : '0;
  assign free_set  = squash_set(live_q, dep_q, bad_set);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      dep_q  <= '0;
    end else begin
      live_q <= (live_q | grant_tag) & ~ok_set & ~free_set;
      for (int t = 0; t < TAGS; t++) begin
        if (grant_tag[t]) dep_q[t] <= live_q & ~ok_set;
        else              dep_q[t] <= dep_q[t] & ~ok_set;
      end
    end
  end
endmodule

// File: rtl/brmask_slot.sv
module brmask_slot
  import brmask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  issue_hit,
  input  logic  release_hit,
  input  tagv_t new_mask,
  input  tagv_t ok_set,
  input  tagv_t bad_set,
  input  tagv_t free_set,
  output logic  valid,
  output tagv_t mask,
  output logic  kill
);
  logic  valid_q, kill_q, valid_n, kill_n;
  tagv_t mask_q, mask_n;

  assign valid = valid_q;
  assign mask  = mask_q;
  assign kill  = kill_q;

  always_comb begin
    valid_n = valid_q;
    mask_n  = mask_q;
    kill_n  = kill_q;
    if (issue_hit) begin
      valid_n = 1'b1;
      mask_n  = new_mask;
      kill_n  = 1'b0;
    end else if (release_hit) begin
      valid_n = 1'b0;
      mask_n  = '0;
      kill_n  = 1'b0;
    end
    if (valid_n) begin
      kill_n = kill_n | (|(mask_n & bad_set));
      mask_n = mask_n & ~ok_set & ~free_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      kill_q  <= 1'b0;
    end else begin
      valid_q <= valid_n;
      mask_q  <= mask_n;
      kill_q  <= kill_n;
    end
  end
endmodule

// File: rtl/brmask_tracker.sv
module brmask_tracker
  import brmask_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_req,
  output logic                      alloc_grant,
  output logic [TAGS-1:0]           alloc_tag,
  output logic                      tags_full,
  input  logic                      issue_valid,
  input  logic [SLOT_W-1:0]         issue_slot,
  input  logic                      release_valid,
  input  logic [SLOT_W-1:0]         release_slot,
  input  logic                      resolve_valid,
  input  logic [TAGS-1:0]           resolve_tag,
  input  logic                      resolve_mispredict,
  output logic [TAGS-1:0]           live_tags,
  output logic [NUM_SLOTS-1:0]      slot_valid,
  output logic [NUM_SLOTS*TAGS-1:0] slot_mask,
  output logic [NUM_SLOTS-1:0]      slot_kill
);
  // Named internal events, also observed by the checker.
  tagv_t live, grant_tag, free_set, resolve_ok_set, resolve_bad_set, issue_mask_w;

  assign resolve_ok_set  = (resolve_valid && !resolve_mispredict) ? (resolve_tag & live) : '0;
  assign resolve_bad_set = (resolve_valid &&  resolve_mispredict) ? (resolve_tag & live) : '0;

  brmask_tag_pool u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (alloc_req),
    .ok_set    (resolve_ok_set),
    .bad_set   (resolve_bad_set),
    .live      (live),
    .grant_tag (grant_tag),
    .free_set  (free_set),
    .grant     (alloc_grant),
    .full      (tags_full)
  );

  assign alloc_tag    = grant_tag;
  assign live_tags    = live;
  assign issue_mask_w = issue_mask(live, grant_tag, resolve_ok_set);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic  issue_hit, release_hit;
    tagv_t mask_i;
    assign issue_hit   = issue_valid   && (issue_slot   == SLOT_W'(i));
    assign release_hit = release_valid && (release_slot == SLOT_W'(i));
    brmask_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_hit   (issue_hit),
      .release_hit (release_hit),
      .new_mask    (issue_mask_w),
      .ok_set      (resolve_ok_set),
      .bad_set     (resolve_bad_set),
      .free_set    (free_set),
      .valid       (slot_valid[i]),
      .mask        (mask_i),
      .kill        (slot_kill[i])
    );
    assign slot_mask[i*TAGS +: TAGS] = mask_i;
  end
endmodule

// File: rtl/brmask_checker.sv
module brmask_checker
  import brmask_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      alloc_grant,
  input logic [TAGS-1:0]           alloc_tag,
  input logic                      tags_full,
  input logic                      issue_valid,
  input logic [SLOT_W-1:0]         issue_slot,
  input logic                      release_valid,
  input logic [SLOT_W-1:0]         release_slot,
  input logic [TAGS-1:0]           resolve_ok_set,
  input logic [TAGS-1:0]           resolve_bad_set,
  input logic [TAGS-1:0]           free_set,
  input logic [TAGS-1:0]           live_tags,
  input logic [NUM_SLOTS-1:0]      slot_valid,
  input logic [NUM_SLOTS*TAGS-1:0] slot_mask,
  input logic [NUM_SLOTS-1:0]      slot_kill
);
  tagv_t mask_union, live_union;
  always_comb begin
    mask_union = '0;
    live_union = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      mask_union = mask_union | slot_mask[i*TAGS +: TAGS];
      if (slot_valid[i] && !slot_kill[i]) live_union = live_union | slot_mask[i*TAGS +: TAGS];
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |-> ($countones(alloc_tag) == 1));
  p_grant_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> ((live_tags & $past(alloc_tag)) != '0));
  p_full_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tags_full |-> (!alloc_grant && alloc_tag == '0));
  p_live_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_union & ~live_tags) == '0);
  p_ok_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_ok_set != '0) |=> (((mask_union | live_tags) & $past(resolve_ok_set)) == '0));
  p_free_younger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_bad_set != '0) |=> ((live_tags & $past(free_set)) == '0));
  p_no_alloc_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_bad_set != '0) |-> !alloc_grant);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_kill
    p_kill_dep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid[i] && ((slot_mask[i*TAGS +: TAGS] & resolve_bad_set) != '0)
       && !(release_valid && release_slot == SLOT_W'(i))
       && !(issue_valid && issue_slot == SLOT_W'(i))) |=> slot_kill[i]);
  end
endmodule

bind brmask_tracker brmask_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .alloc_grant     (alloc_grant),
  .alloc_tag       (alloc_tag),
  .tags_full       (tags_full),
  .issue_valid     (issue_valid),
  .issue_slot      (issue_slot),
  .release_valid   (release_valid),
  .release_slot    (release_slot),
  .resolve_ok_set  (resolve_ok_set),
  .resolve_bad_set (resolve_bad_set),
  .free_set        (free_set),
  .live_tags       (live_tags),
  .slot_valid      (slot_valid),
  .slot_mask       (slot_mask),
  .slot_kill       (slot_kill)
);

// File: tb/test_brmask_tracker.sv
module test_brmask_tracker;
  localparam int NT = 4;
  localparam int NS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0, issue_valid = 1'b0, release_valid = 1'b0;
  logic resolve_valid = 1'b0, resolve_mispredict = 1'b0;
  logic [3:0] issue_slot = '0, release_slot = '0, resolve_tag = '0;
  logic alloc_grant, tags_full;
  logic [NT-1:0] alloc_tag, live_tags;
  logic [NS-1:0] slot_valid, slot_kill;
  logic [NS*NT-1:0] slot_mask;

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural reference state.
  int m_live[NT];
  int m_dep[NT][NT];
  int s_v[NS], s_k[NS];
  int s_m[NS][NT];

  always #4 clk = ~clk;

  brmask_tracker i_brmask_tracker (.*);

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int vec_of(int arr[NT]);
    int r = 0;
    foreach (arr[u]) if (arr[u] != 0) r += (1 << u);
    return r;
  endfunction

  task automatic check_regs(string req);
    check(req, "live_tags", int'(live_tags), vec_of(m_live));
    for (int i = 0; i < NS; i++) begin
      int em = 0;
      for (int u = 0; u < NT; u++) if (s_m[i][u] != 0) em += (1 << u);
      check(req, $sformatf("slot%0d valid", i), int'(slot_valid[i]), s_v[i]);
      check(req, $sformatf("slot%0d mask", i), int'(slot_mask[i*NT +: NT]), em);
      check(req, $sformatf("slot%0d kill", i), int'(slot_kill[i]), s_k[i]);
    end
  endtask

  // One clock: drive, check same-cycle outputs, advance model, check registers.
  task automatic step(string req, bit a, bit iv, int is, bit rv, int rs, bit zv, int zt, bit zb);
    int full, grant, g, hit, ok, bad;
    int freed[NT];
    int old_live[NT];
    @(negedge clk);
    alloc_req = a; issue_valid = iv; issue_slot = 4'(is);
    release_valid = rv; release_slot = 4'(rs);
    resolve_valid = zv; resolve_tag = 4'(1 << zt); resolve_mispredict = zb;
    #2;
    full = 1;
    foreach (m_live[u]) if (m_live[u] == 0) full = 0;
    hit = (zv && m_live[zt] != 0) ? 1 : 0;
    ok = hit && !zb;
    bad = hit && zb;
    grant = (a && !full && !bad) ? 1 : 0;
    g = -1;
    if (grant) for (int u = NT - 1; u >= 0; u--) if (m_live[u] == 0) g = u;
    check(req, "tags_full", int'(tags_full), full);
    check(req, "alloc_grant", int'(alloc_grant), grant);
    check(req, "alloc_tag", int'(alloc_tag), (g >= 0) ? (1 << g) : 0);
    foreach (freed[u]) freed[u] = 0;
    if (bad) begin
      freed[zt] = 1;
      for (int u = 0; u < NT; u++) if (m_live[u] != 0 && m_dep[u][zt] != 0) freed[u] = 1;
    end
    old_live = m_live;
    for (int i = 0; i < NS; i++) begin
      if (iv && is == i) begin
        s_v[i] = 1; s_k[i] = 0;
        for (int u = 0; u < NT; u++) s_m[i][u] = (old_live[u] != 0 || u == g) ? 1 : 0;
      end else if (rv && rs == i) begin
        s_v[i] = 0; s_k[i] = 0;
        for (int u = 0; u < NT; u++) s_m[i][u] = 0;
      end
      if (s_v[i] != 0) begin
        if (bad && s_m[i][zt] != 0) s_k[i] = 1;
        for (int u = 0; u < NT; u++) if ((ok && u == zt) || freed[u] != 0) s_m[i][u] = 0;
      end
    end
    if (g >= 0) begin
      m_live[g] = 1;
      for (int u = 0; u < NT; u++) m_dep[g][u] = (old_live[u] != 0 && !(ok && u == zt)) ? 1 : 0;
    end
    for (int t = 0; t < NT; t++) begin
      if (ok && t != g) m_dep[t][zt] = 0;
      if (freed[t] != 0) m_live[t] = 0;
    end
    if (ok) m_live[zt] = 0;
    @(posedge clk);
    #1;
    check_regs(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (m_live[u]) m_live[u] = 0;
    foreach (m_dep[t, u]) m_dep[t][u] = 0;
    foreach (s_v[i]) begin s_v[i] = 0; s_k[i] = 0; end
    foreach (s_m[i, u]) s_m[i][u] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1", "tags_full", int'(tags_full), 0);
    check_regs("R1");

    step("R2", 1, 0, 0, 0, 0, 0, 0, 0);          // tag0
    step("R4", 1, 1, 0, 0, 0, 0, 0, 0);          // tag1 + slot0 mask 0011
    step("R2", 1, 0, 0, 0, 0, 0, 0, 0);          // tag2
    step("R2", 1, 0, 0, 0, 0, 0, 0, 0);          // tag3
    step("R3", 1, 1, 1, 0, 0, 0, 0, 0);          // refused, slot1 mask 1111
    step("R5", 0, 0, 0, 0, 0, 1, 1, 0);          // tag1 correct
    step("R9", 0, 0, 0, 0, 0, 1, 1, 1);          // tag1 not live: no effect
    step("R4", 0, 1, 2, 0, 0, 0, 0, 0);          // slot2 mask 1101
    step("R4", 1, 1, 3, 0, 0, 0, 0, 0);          // tag1 again, slot3 1111
    step("R3", 1, 0, 0, 0, 0, 0, 0, 0);          // full, refused
    step("R7", 1, 1, 4, 0, 0, 1, 2, 1);          // tag2 wrong: R6 R8 R11
    step("R10", 0, 0, 0, 1, 1, 0, 0, 0);         // release slot1
    step("R10", 0, 1, 2, 1, 2, 0, 0, 0);         // issue beats release
    step("R11", 0, 1, 5, 0, 0, 1, 0, 0);         // tag0 correct with issue
    step("R2", 1, 1, 6, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 7, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 1, 1, 1);          // tag1 wrong, tag0 older kept

    void'($urandom(7));
    for (int c = 0; c < 600; c++) begin
      step("R6", ($urandom % 2) == 0, ($urandom % 3) == 0, int'($urandom % NS),
           ($urandom % 3) == 0, int'($urandom % NS),
           ($urandom % 3) == 0, int'($urandom % NT), ($urandom % 3) == 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule